// File: doc/BRIEF.md
# Decimal Correction Unit

This block applies the six decimal-correction steps used after binary arithmetic on a 16-bit accumulator pair (a high byte and a low byte). Two of them fix up unpacked (one digit per byte) sums and differences. Two fix up packed (two digits per byte) sums and differences. The last two split a byte into two unpacked digits by dividing by ten, or merge two unpacked digits into one binary byte by multiplying by ten. The unit takes an operation code, the 16-bit accumulator value and the incoming carry and half-carry flags. It returns the corrected accumulator, a flag vector and a mask that marks which flags the selected operation defines.

Operands enter through a valid/ready handshake and are accepted in one cycle. The result is registered and shown on the output side one cycle after acceptance. It stays there until the consumer takes it. With the consumer always ready, the unit takes a new operation every cycle. A small controller with two states manages the result register. `ST_EMPTY` means no result is held, and in this state `in_ready` is high. `ST_FULL` means a result is held and `out_valid` is high. The controller has four transitions: `T_ACCEPT` (EMPTY to FULL when an operation is taken), `T_DRAIN` (FULL to EMPTY when the result is taken and nothing new arrives), `T_RELOAD` (FULL to FULL when the result is taken and a new operation is accepted in the same cycle) and `T_STALL` (FULL to FULL while the consumer is not ready).

Top module: `dadj_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An operation accepted (`in_valid` and `in_ready` both high at a rising edge) appears with `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0, the result stays stable, `out_valid` stays 1 and `in_ready` is 0.
- R3: Op code 0 (unpacked add correction): the test is met when the low nibble of the low byte is above 9 or the incoming half-carry is 1. If the test is met, 6 is added to the low byte, 1 is added to the high byte, and C and A are set. If not, C and A are cleared. In both cases the upper nibble of the low byte is then cleared.
- R4: Op code 1 (unpacked subtract correction): the same test as R3 is used, but 6 is subtracted from the low byte and 1 from the high byte. Example: 02FFh gives 0109h with C=A=1.
- R5: Op code 2 (split by ten): the high byte becomes the low byte divided by 10, and the low byte becomes the remainder.
- R6: Op code 3 (merge by ten): the low byte becomes high×10 + low, taken modulo 256, and the high byte becomes 0.
- R7: Op code 4 (packed add correction): if the low nibble is above 9 or A is 1, add 6 to the low byte and set A; otherwise clear A. Then, if that intermediate byte is above 9Fh or the incoming C is 1, add 60h and set C; otherwise clear C. The high byte is unchanged, and all arithmetic wraps modulo 256.
- R8: Op code 5 (packed subtract correction): the same two tests as R7 are used, with 6 and 60h subtracted instead. Example: FFh gives 99h with C=1.
- R9: Where Z, S and P are defined, they describe the resulting low byte. Z is 1 when the byte is zero, S is its bit 7, and P is 1 when the byte has an even number of ones.
- R10: The flag and mask bit positions are [0]=C, [1]=Z, [2]=S, [3]=O, [4]=P, [5]=A. The mask is 100001b for op codes 0 and 1, 010110b for op codes 2 and 3, and 110111b for op codes 4 and 5. Every flag bit outside the mask reads 0.
- R11: Op codes 6 and 7 are reserved. For these, the accumulator passes through unchanged and the flags and mask are all zero.
- R12: With `out_ready` held at 1, operations given on consecutive cycles are all accepted, and each result appears on the cycle after its input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 3 | Operation code (see R3 to R11) |
| in_ax | input | 16 | Accumulator: high byte [15:8], low byte [7:0] |
| in_cf | input | 1 | Incoming carry flag |
| in_af | input | 1 | Incoming half-carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ax | output | 16 | Corrected accumulator |
| out_flags | output | 6 | New flags, positions per R10 |
| out_mask | output | 6 | Defined-flag mask, positions per R10 |

## Verification
Each correction is driven with low bytes on both sides of its test. The cases cover a nibble above 9, a nibble at or below 9 with the half-carry set, and a nibble at or below 9 with the half-carry clear, so a swapped or missing condition term shows up. The packed operations also use bytes that move past 9Fh only after the first step, and a byte that needs the second step only because of the incoming carry. This separates the two-stage test from a single combined one. The multiply-by-ten merge is given inputs that overflow a byte and inputs that set the sign bit, and the division split is given 0, 15 and 255. Only the flags marked in the mask are compared. Separate cases stall and stream the handshake.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NFLAG  = 6;

    // flag positions
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_S = 2;
    localparam int FL_O = 3;
    localparam int FL_P = 4;
    localparam int FL_A = 5;

    typedef enum logic [2:0] {
        OP_UADD  = 3'd0,
        OP_USUB  = 3'd1,
        OP_SPLIT = 3'd2,
        OP_MERGE = 3'd3,
        OP_PADD  = 3'd4,
        OP_PSUB  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } dadj_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] ax;
        logic [NFLAG-1:0]  flags;
        logic [NFLAG-1:0]  mask;
    } dadj_res_t;

    localparam logic [NFLAG-1:0] MASK_UNPK = NFLAG'((1 << FL_C) | (1 << FL_A));
    localparam logic [NFLAG-1:0] MASK_SCAL = NFLAG'((1 << FL_Z) | (1 << FL_S) | (1 << FL_P));
    localparam logic [NFLAG-1:0] MASK_PACK = MASK_UNPK | MASK_SCAL;

endpackage

// File: rtl/dadj_unpacked.sv
module dadj_unpacked #(
    parameter int BW = 8
) (
    input  logic          is_sub,
    input  logic [BW-1:0] lo_i,
    input  logic [BW-1:0] hi_i,
    input  logic          af_i,
    output logic [BW-1:0] lo_o,
    output logic [BW-1:0] hi_o,
    output logic          carry_o
);
    localparam logic [BW-1:0] STEP_LO = BW'(6);
    localparam logic [BW-1:0] STEP_HI = BW'(1);
    localparam logic [3:0]    DIGMAX  = 4'd9;

    logic          need;
    logic [BW-1:0] lo_t;
    logic [BW-1:0] hi_t;

    always_comb begin
        need = (lo_i[3:0] > DIGMAX) || af_i;
        lo_t = is_sub ? (lo_i - STEP_LO) : (lo_i + STEP_LO);
        hi_t = is_sub ? (hi_i - STEP_HI) : (hi_i + STEP_HI);
        lo_o = '0;
        if (need) begin
            lo_o[3:0] = lo_t[3:0];
            hi_o      = hi_t;
        end else begin
            lo_o[3:0] = lo_i[3:0];
            hi_o      = hi_i;
        end
        carry_o = need;
    end
endmodule

// File: rtl/dadj_packed.sv
module dadj_packed #(
    parameter int BW = 8
) (
    input  logic          is_sub,
    input  logic [BW-1:0] lo_i,
    input  logic          cf_i,
    input  logic          af_i,
    output logic [BW-1:0] lo_o,
    output logic          cf_o,
    output logic          af_o
);
    localparam logic [BW-1:0] STEP_LO = BW'(6);
    localparam logic [BW-1:0] STEP_HI = BW'(8'h60);
    localparam logic [BW-1:0] HI_LIM  = BW'(8'h9F);
    localparam logic [3:0]    DIGMAX  = 4'd9;

    logic [BW-1:0] mid;

    always_comb begin
        af_o = (lo_i[3:0] > DIGMAX) || af_i;
        if (af_o) mid = is_sub ? (lo_i - STEP_LO) : (lo_i + STEP_LO);
        else      mid = lo_i;
        cf_o = (mid > HI_LIM) || cf_i;
        if (cf_o) lo_o = is_sub ? (mid - STEP_HI) : (mid + STEP_HI);
        else      lo_o = mid;
    end
endmodule

// File: rtl/dadj_scale.sv
module dadj_scale #(
    parameter int BW    = 8,
    parameter int RADIX = 10
) (
    input  logic          do_merge,
    input  logic [BW-1:0] lo_i,
    input  logic [BW-1:0] hi_i,
    output logic [BW-1:0] lo_o,
    output logic [BW-1:0] hi_o
);
    localparam logic [BW-1:0] RDX = BW'(RADIX);

    logic [BW-1:0] quot;
    logic [BW-1:0] rem;
    logic [BW-1:0] merged;

    always_comb begin
        quot   = lo_i / RDX;
        rem    = lo_i % RDX;
        merged = (hi_i * RDX) + lo_i;
        if (do_merge) begin
            lo_o = merged;
            hi_o = '0;
        end else begin
            lo_o = rem;
            hi_o = quot;
        end
    end
endmodule

// File: rtl/dadj_ctrl.sv
module dadj_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load
);
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } st_e;

    st_e state_q;
    st_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;              // T_ACCEPT
            ST_FULL: begin
                if (out_ready && !in_valid) state_d = ST_EMPTY;     // T_DRAIN
                else                        state_d = ST_FULL;      // T_RELOAD / T_STALL
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: in_ready = 1'b1;
            ST_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
            end
            default: in_ready = 1'b0;
        endcase
        load = in_valid && in_ready;
    end
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
    import dadj_pkg::*;
#(
    parameter int RADIX = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2:0]           in_op,
    input  logic [WORD_W-1:0]    in_ax,
    input  logic                 in_cf,
    input  logic                 in_af,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [WORD_W-1:0]    out_ax,
    output logic [NFLAG-1:0]     out_flags,
    output logic [NFLAG-1:0]     out_mask
);
    localparam int BW = BYTE_W;

    logic [BW-1:0] lo_in;
    logic [BW-1:0] hi_in;
    dadj_op_e      op;

    assign lo_in = in_ax[BW-1:0];
    assign hi_in = in_ax[WORD_W-1:BW];
    assign op    = dadj_op_e'(in_op);

    logic [BW-1:0] u_lo, u_hi;
    logic          u_c;
    logic [BW-1:0] p_lo;
    logic          p_c, p_a;
    logic [BW-1:0] s_lo, s_hi;
    logic          load;

    dadj_unpacked #(.BW(BW)) unpk_i (
        .is_sub  (op == OP_USUB),
        .lo_i    (lo_in),
        .hi_i    (hi_in),
        .af_i    (in_af),
        .lo_o    (u_lo),
        .hi_o    (u_hi),
        .carry_o (u_c)
    );

    dadj_packed #(.BW(BW)) pack_i (
        .is_sub (op == OP_PSUB),
        .lo_i   (lo_in),
        .cf_i   (in_cf),
        .af_i   (in_af),
        .lo_o   (p_lo),
        .cf_o   (p_c),
        .af_o   (p_a)
    );

    dadj_scale #(.BW(BW), .RADIX(RADIX)) scal_i (
        .do_merge (op == OP_MERGE),
        .lo_i     (lo_in),
        .hi_i     (hi_in),
        .lo_o     (s_lo),
        .hi_o     (s_hi)
    );

    dadj_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load)
    );

    function automatic logic [NFLAG-1:0] byte_flags(input logic [BW-1:0] b);
        logic [NFLAG-1:0] f;
        f       = '0;
        f[FL_Z] = (b == '0);
        f[FL_S] = b[BW-1];
        f[FL_P] = ~(^b);
        return f;
    endfunction

    dadj_res_t nxt;
    dadj_res_t res_q;

    always_comb begin
        nxt = '0;
        unique case (op)
            OP_UADD, OP_USUB: begin
                nxt.ax          = {u_hi, u_lo};
                nxt.flags[FL_C] = u_c;
                nxt.flags[FL_A] = u_c;
                nxt.mask        = MASK_UNPK;
            end
            OP_SPLIT, OP_MERGE: begin
                nxt.ax    = {s_hi, s_lo};
                nxt.flags = byte_flags(s_lo);
                nxt.mask  = MASK_SCAL;
            end
            OP_PADD, OP_PSUB: begin
                nxt.ax          = {hi_in, p_lo};
                nxt.flags       = byte_flags(p_lo);
                nxt.flags[FL_C] = p_c;
                nxt.flags[FL_A] = p_a;
                nxt.mask        = MASK_PACK;
            end
            default: begin
                nxt.ax = in_ax;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    res_q <= '0;
        else if (load) res_q <= nxt;
    end

    assign out_ax    = res_q.ax;
    assign out_flags = res_q.flags;
    assign out_mask  = res_q.mask;

endmodule

// File: rtl/dadj_unit_chk.sv
module dadj_unit_chk
    import dadj_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_ax,
    input logic [NFLAG-1:0]  out_flags,
    input logic [NFLAG-1:0]  out_mask
);
    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_ax)
                                       && $stable(out_flags) && $stable(out_mask)));

    // R2
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R12
    accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R10
    mask_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask == MASK_UNPK || out_mask == MASK_SCAL
                       || out_mask == MASK_PACK || out_mask == '0));

    // R10
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_flags & ~out_mask) == '0));

    // R3
    unpk_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mask == MASK_UNPK) |-> (out_ax[7:4] == 4'h0));
endmodule

bind dadj_unit dadj_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_ax    (out_ax),
    .out_flags (out_flags),
    .out_mask  (out_mask)
);

// File: tb/dadj_unit_tb_top.sv
`timescale 1ns/1ps
module dadj_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [2:0]  in_op;
    logic [15:0] in_ax;
    logic        in_cf;
    logic        in_af;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_ax;
    logic [5:0]  out_flags;
    logic [5:0]  out_mask;

    int n_chk = 0;
    int n_err = 0;

    localparam logic [5:0] M_U = 6'b100001;
    localparam logic [5:0] M_S = 6'b010110;
    localparam logic [5:0] M_P = 6'b110111;

    always #2.5 clk = ~clk;

    dadj_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_ax(in_ax), .in_cf(in_cf), .in_af(in_af),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_ax(out_ax), .out_flags(out_flags), .out_mask(out_mask)
    );

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_res(input string tag, input logic [15:0] ax,
                             input logic [5:0] fl, input logic [5:0] mk);
        n_chk++;
        if (out_valid !== 1'b1 || out_ax !== ax || out_mask !== mk
            || (out_flags & mk) !== (fl & mk)) begin
            n_err++;
            $display("FAIL %s: got v=%0b ax=%h fl=%b mk=%b expected v=1 ax=%h fl=%b mk=%b",
                     tag, out_valid, out_ax, out_flags & mk, out_mask, ax, fl & mk, mk);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [15:0] ax,
                         input logic cf, input logic af);
        in_valid = 1'b1; in_op = op; in_ax = ax; in_cf = cf; in_af = af;
    endtask

    // one op, consumer ready, check at negedge after accepting edge
    task automatic run_op(input string tag, input logic [2:0] op, input logic [15:0] ax,
                          input logic cf, input logic af,
                          input logic [15:0] eax, input logic [5:0] efl, input logic [5:0] emk);
        out_ready = 1'b1;
        drive(op, ax, cf, af);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        check_res(tag, eax, efl, emk);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset;
        check_bit("R1 out_valid after reset", out_valid, 1'b0);
        check_bit("R1 in_ready after reset", in_ready, 1'b1);
    endtask

    task automatic t_unpacked;
        run_op("R3 nibble above 9", 3'd0, 16'h000F, 0, 0, 16'h0105, 6'b100001, M_U);
        run_op("R3 af set",         3'd0, 16'h0002, 0, 1, 16'h0108, 6'b100001, M_U);
        run_op("R3 no adjust",      3'd0, 16'h0073, 1, 0, 16'h0003, 6'b000000, M_U);
        run_op("R4 borrow adjust",  3'd1, 16'h02FF, 0, 0, 16'h0109, 6'b100001, M_U);
        run_op("R4 no adjust",      3'd1, 16'h0505, 0, 0, 16'h0505, 6'b000000, M_U);
    endtask

    task automatic t_scale;
        run_op("R5 split 15",  3'd2, 16'h000F, 0, 0, 16'h0105, 6'b010000, M_S);
        run_op("R5 split 255", 3'd2, 16'h77FF, 0, 0, 16'h1905, 6'b010000, M_S);
        run_op("R9 split zero",3'd2, 16'h3300, 0, 0, 16'h0000, 6'b010010, M_S);
        run_op("R6 merge 15",  3'd3, 16'h0105, 0, 0, 16'h000F, 6'b010000, M_S);
        run_op("R6 merge wrap",3'd3, 16'h1A0A, 0, 0, 16'h000E, 6'b000000, M_S);
        run_op("R9 merge sign",3'd3, 16'h0D00, 0, 0, 16'h0082, 6'b010100, M_S);
    endtask

    task automatic t_packed;
        run_op("R7 low step only",  3'd4, 16'h120F, 0, 0, 16'h1215, 6'b100000, M_P);
        run_op("R7 both steps wrap",3'd4, 16'h009A, 0, 0, 16'h0000, 6'b110011, M_P);
        run_op("R7 carry in only",  3'd4, 16'h0023, 1, 0, 16'h0083, 6'b000101, M_P);
        run_op("R8 both steps",     3'd5, 16'h00FF, 0, 0, 16'h0099, 6'b110101, M_P);
        run_op("R8 no adjust",      3'd5, 16'hAB45, 0, 0, 16'hAB45, 6'b000000, M_P);
    endtask

    task automatic t_reserved;
        run_op("R11 op 6", 3'd6, 16'h1234, 1, 1, 16'h1234, 6'b000000, 6'b000000);
        run_op("R11 op 7", 3'd7, 16'hFEDC, 1, 1, 16'hFEDC, 6'b000000, 6'b000000);
        n_chk++;
        if (out_flags !== 6'b0) begin
            n_err++;
            $display("FAIL R11 flags: got %b expected 000000", out_flags);
        end
    endtask

    task automatic t_hold;
        out_ready = 1'b0;
        drive(3'd2, 16'h000F, 0, 0);
        @(posedge clk); @(negedge clk);
        drive(3'd3, 16'h0909, 0, 0);
        for (int i = 0; i < 3; i++) begin
            check_res("R2 held result", 16'h0105, 6'b010000, M_S);
            check_bit("R2 in_ready low in stall", in_ready, 1'b0);
            @(posedge clk); @(negedge clk);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        check_bit("R2 drained", out_valid, 1'b0);
    endtask

    task automatic t_stream;
        out_ready = 1'b1;
        drive(3'd0, 16'h000F, 0, 0);
        @(posedge clk); @(negedge clk);
        check_bit("R12 ready while streaming", in_ready, 1'b1);
        check_res("R12 first", 16'h0105, 6'b100001, M_U);
        drive(3'd3, 16'h0909, 0, 0);
        @(posedge clk); @(negedge clk);
        check_res("R12 second", 16'h0063, 6'b010000, M_S);
        drive(3'd5, 16'h00FF, 0, 0);
        @(posedge clk); @(negedge clk);
        check_res("R12 third", 16'h0099, 6'b110101, M_P);
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check_bit("R12 idle after stream", out_valid, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_ax = '0;
        in_cf = 1'b0; in_af = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        t_reset();
        t_unpacked();
        t_scale();
        t_packed();
        t_reserved();
        t_hold();
        t_stream();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule